// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a two-channel serial audio stream and turns it into parallel samples. The stream has three wires: a bit clock, an alignment clock that marks which channel is being sent, and one data line that carries left and right words in turn. All three are inputs; the block is a slave. It oversamples them in the system clock domain and finds bit-clock rising edges there, so the system clock must run at least four times faster than the bit clock.

One shift engine decodes four framings, picked by a two-bit format input. They differ in where the first bit of a word sits relative to the alignment edge: left-justified, delayed by one bit (I2S), right-justified, and pulse-framed. The word length can be set at run time. Each finished word leaves the block as a one-cycle strobe with the sample right-aligned and a left/right tag. A format and length pair that the block cannot handle raises an error flag and is not applied.

Top module: `audio_serial_rx`

## Requirements
- R1: Format code 0 (left-justified): the MSB is the bit sampled on the first bit-clock rising edge after the alignment clock changes level; a high alignment clock means left.
- R2: Format code 1 (I2S): the MSB is the bit sampled on the second bit-clock rising edge after an alignment change; a low alignment clock means left.
- R3: Format code 2 (right-justified): the sample is the last N bits sampled before an alignment change, and it belongs to the channel of the half that just ended (high = left). The largest accepted length is one below the maximum (31 by default).
- R4: Format code 3 (pulse-framed): the first bit-clock rising edge that sees the alignment line high after it was low marks the frame. The left word starts on the next rising edge, and the right word starts on the rising edge right after the left word's LSB.
- R5: In every format, data is shifted MSB first. The sample is delivered in bits N-1..0 of the data output, and every bit above N-1 is zero.
- R6: A length from 16 to 32 is applied together with its format code. A pair with a length outside that range, or format code 2 with length 32, is ignored: the error output is high in the following cycle, and the previously applied format and length stay in force.
- R7: Bits received after the N-th bit of a word are discarded.
- R8: In formats 0, 1 and 3, when a frame event arrives before N bits have been received, the word is delivered with its missing LSBs filled with zeros.
- R9: Each completed word raises the valid output for exactly one system-clock cycle. The channel output is 0 for left and 1 for right.
- R10: During reset all outputs are low. After reset, the first bit-clock rising edge only records the alignment level and is never taken as an alignment change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing code: 0 left-justified, 1 I2S, 2 right-justified, 3 pulse-framed |
| word_len_i | input | LEN_W (6) | Requested word length in bits |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| lrck_i | input | 1 | Alignment clock / frame pulse (asynchronous) |
| sdata_i | input | 1 | Serial audio data (asynchronous) |
| smp_valid_o | output | 1 | One-cycle strobe for a completed word |
| smp_right_o | output | 1 | Channel of the delivered word: 0 left, 1 right |
| smp_data_o | output | MAX_W (32) | Sample, right-aligned in the low N bits |
| cfg_err_o | output | 1 | High for a cycle when the requested setting is rejected |

## Verification
The bench builds the block with its defaults: a 32-bit maximum word, a 16-bit minimum and two synchroniser stages, with the bit clock running at one eighth of the system clock. With these values the bench can send full 32-bit left-justified words and check the right-justified limit at 31, where 32 must be refused. It can also try lengths 15 and 33, one step outside the legal range on each side, and run words that are shorter and longer than their slots in each format.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT_J  = 2'd0,
    FMT_I2S_DLY = 2'd1,
    FMT_RIGHT_J = 2'd2,
    FMT_PULSE   = 2'd3
  } fmt_e;

  // n low bits set
  function automatic logic [63:0] low_ones(input int unsigned n);
    if (n >= 64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // word of 'got' bits, MSB aligned into a field of 'len' bits, LSBs zero
  function automatic logic [63:0] pad_lsbs(input logic [63:0] v,
                                           input int unsigned got,
                                           input int unsigned len);
    int unsigned gap;
    gap = (got >= len) ? 0 : len - got;
    return (v << gap) & low_ones(len);
  endfunction

  // legal format / length pair
  function automatic logic cfg_legal(input fmt_e f, input int unsigned len,
                                     input int unsigned lo, input int unsigned hi);
    if (len < lo || len > hi) return 1'b0;
    if (f == FMT_RIGHT_J && len >= hi) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stage_q[s] <= stage_q[s-1];
      stage_q[0] <= async_i;
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/aud_rx_cfg.sv
module aud_rx_cfg
  import aud_rx_pkg::*;
#(
  parameter int MIN_W = 16,
  parameter int MAX_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_i,
  input  logic [LEN_W-1:0] len_i,
  output fmt_e             fmt_q,
  output logic [LEN_W-1:0] len_q,
  output logic             err_q
);

  logic legal;
  assign legal = cfg_legal(fmt_e'(fmt_i), 32'(len_i), MIN_W, MAX_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_LEFT_J;
      len_q <= LEN_W'(MIN_W);
      err_q <= 1'b0;
    end else begin
      err_q <= !legal;
      if (legal) begin
        fmt_q <= fmt_e'(fmt_i);
        len_q <= len_i;
      end
    end
  end

endmodule

// File: rtl/aud_rx_engine.sv
module aud_rx_engine
  import aud_rx_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  logic [LEN_W-1:0] len,
  input  logic             sclk_s,
  input  logic             lr_bit,
  input  logic             data_bit,
  output logic             bit_rise_o,
  output logic             frame_evt_o,
  output logic             word_done_o,
  output logic             active_o,
  output logic             valid_o,
  output logic             right_o,
  output logic [MAX_W-1:0] data_o
);

  logic             sclk_d, primed, lr_prev, active, chan_r, arm, arm_r, rj_seen;
  logic [LEN_W-1:0] cnt;
  logic [MAX_W-1:0] acc, win;

  logic             n_primed, n_lr_prev, n_active, n_chan_r, n_arm, n_arm_r, n_rj_seen;
  logic [LEN_W-1:0] n_cnt;
  logic [MAX_W-1:0] n_acc, n_win;

  logic             bit_rise, lr_chg, pulse_rise, frame_evt;
  logic             emit, e_right;
  logic [MAX_W-1:0] e_data;

  assign bit_rise   = sclk_s & ~sclk_d;
  assign lr_chg     = primed && (lr_bit != lr_prev);
  assign pulse_rise = primed && lr_bit && !lr_prev;
  assign frame_evt  = bit_rise && ((fmt == FMT_PULSE) ? pulse_rise : lr_chg);

  always_comb begin : p_next
    logic [MAX_W-1:0] acc_t;
    logic [LEN_W-1:0] cnt_t;
    acc_t     = {acc[MAX_W-2:0], data_bit};
    cnt_t     = cnt + LEN_W'(1);
    n_primed  = primed;
    n_lr_prev = lr_prev;
    n_active  = active;
    n_chan_r  = chan_r;
    n_arm     = arm;
    n_arm_r   = arm_r;
    n_rj_seen = rj_seen;
    n_cnt     = cnt;
    n_acc     = acc;
    n_win     = win;
    emit      = 1'b0;
    e_right   = 1'b0;
    e_data    = '0;
    if (bit_rise) begin
      n_primed  = 1'b1;
      n_lr_prev = lr_bit;
      n_win     = {win[MAX_W-2:0], data_bit};
      if (fmt == FMT_RIGHT_J) begin
        // window closes at the alignment change, before this bit
        if (lr_chg) begin
          emit      = rj_seen;
          e_right   = !lr_prev;
          e_data    = MAX_W'(64'(win) & low_ones(32'(len)));
          n_rj_seen = 1'b1;
        end
        n_active = 1'b0;
        n_arm    = 1'b0;
      end else if (frame_evt) begin
        if (active) begin
          // one-bit delayed format: this bit still belongs to the old word
          if (fmt != FMT_I2S_DLY) begin
            acc_t = acc;
            cnt_t = cnt;
          end
          emit    = 1'b1;
          e_right = chan_r;
          e_data  = MAX_W'(pad_lsbs(64'(acc_t), 32'(cnt_t), 32'(len)));
        end
        case (fmt)
          FMT_LEFT_J: begin
            n_acc    = MAX_W'(data_bit);
            n_cnt    = LEN_W'(1);
            n_active = 1'b1;
            n_chan_r = !lr_bit;
            n_arm    = 1'b0;
          end
          FMT_I2S_DLY: begin
            n_active = 1'b0;
            n_arm    = 1'b1;
            n_arm_r  = lr_bit;
          end
          default: begin
            n_active = 1'b0;
            n_arm    = 1'b1;
            n_arm_r  = 1'b0;
          end
        endcase
      end else if (arm) begin
        n_acc    = MAX_W'(data_bit);
        n_cnt    = LEN_W'(1);
        n_active = 1'b1;
        n_chan_r = arm_r;
        n_arm    = 1'b0;
      end else if (active) begin
        n_acc = acc_t;
        n_cnt = cnt_t;
        if (cnt_t == len) begin
          emit     = 1'b1;
          e_right  = chan_r;
          e_data   = MAX_W'(pad_lsbs(64'(acc_t), 32'(cnt_t), 32'(len)));
          n_active = 1'b0;
          if (fmt == FMT_PULSE && !chan_r) begin
            n_arm   = 1'b1;
            n_arm_r = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      primed  <= 1'b0;
      lr_prev <= 1'b0;
      active  <= 1'b0;
      chan_r  <= 1'b0;
      arm     <= 1'b0;
      arm_r   <= 1'b0;
      rj_seen <= 1'b0;
      cnt     <= '0;
      acc     <= '0;
      win     <= '0;
      valid_o <= 1'b0;
      right_o <= 1'b0;
      data_o  <= '0;
    end else begin
      sclk_d  <= sclk_s;
      primed  <= n_primed;
      lr_prev <= n_lr_prev;
      active  <= n_active;
      chan_r  <= n_chan_r;
      arm     <= n_arm;
      arm_r   <= n_arm_r;
      rj_seen <= n_rj_seen;
      cnt     <= n_cnt;
      acc     <= n_acc;
      win     <= n_win;
      valid_o <= emit;
      if (emit) begin
        right_o <= e_right;
        data_o  <= e_data;
      end
    end
  end

  assign bit_rise_o  = bit_rise;
  assign frame_evt_o = frame_evt;
  assign word_done_o = emit;
  assign active_o    = active;

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int MAX_W       = 32,
  parameter int MIN_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W      = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fmt_i,
  input  logic [LEN_W-1:0] word_len_i,
  input  logic             sclk_i,
  input  logic             lrck_i,
  input  logic             sdata_i,
  output logic             smp_valid_o,
  output logic             smp_right_o,
  output logic [MAX_W-1:0] smp_data_o,
  output logic             cfg_err_o
);

  logic [2:0]       line_s;
  fmt_e             fmt_q;
  logic [LEN_W-1:0] len_q;
  logic             bit_rise, frame_evt, word_done, word_active;

  aud_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdata_i, lrck_i, sclk_i}),
    .sync_o  (line_s)
  );

  aud_rx_cfg #(.MIN_W(MIN_W), .MAX_W(MAX_W), .LEN_W(LEN_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .fmt_i (fmt_i),
    .len_i (word_len_i),
    .fmt_q (fmt_q),
    .len_q (len_q),
    .err_q (cfg_err_o)
  );

  aud_rx_engine #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt         (fmt_q),
    .len         (len_q),
    .sclk_s      (line_s[0]),
    .lr_bit      (line_s[1]),
    .data_bit    (line_s[2]),
    .bit_rise_o  (bit_rise),
    .frame_evt_o (frame_evt),
    .word_done_o (word_done),
    .active_o    (word_active),
    .valid_o     (smp_valid_o),
    .right_o     (smp_right_o),
    .data_o      (smp_data_o)
  );

endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int MAX_W = 32,
  parameter int MIN_W = 16,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             cfg_err,
  input logic [1:0]       fmt_q,
  input logic [LEN_W-1:0] len_q,
  input logic [MAX_W-1:0] smp_data,
  input logic             word_done
);

  AST_STROBE_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(word_done)); // R9

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R9

  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LEN_W'(MIN_W)) && (len_q <= LEN_W'(MAX_W))); // R6

  AST_RJ_SHORT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == 2'd2) |-> (len_q < LEN_W'(MAX_W))); // R3

  AST_ERR_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($stable(len_q) && $stable(fmt_q))); // R6

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ((smp_data >> $past(len_q)) == '0)); // R5

endmodule

bind audio_serial_rx aud_rx_chk #(.MAX_W(MAX_W), .MIN_W(MIN_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid_o),
  .cfg_err   (cfg_err_o),
  .fmt_q     (fmt_q),
  .len_q     (len_q),
  .smp_data  (smp_data_o),
  .word_done (word_done)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [5:0]  word_len_i = 6'd16;
  logic        sclk_i = 1'b0, lrck_i = 1'b0, sdata_i = 1'b0;
  logic        smp_valid_o, smp_right_o, cfg_err_o;
  logic [31:0] smp_data_o;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  string cur_tag = "R10";

  logic [31:0] q_data[$];
  logic        q_right[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .word_len_i(word_len_i),
    .sclk_i(sclk_i), .lrck_i(lrck_i), .sdata_i(sdata_i),
    .smp_valid_o(smp_valid_o), .smp_right_o(smp_right_o),
    .smp_data_o(smp_data_o), .cfg_err_o(cfg_err_o)
  );

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && smp_valid_o) begin
      strobes++;
      checks++;
      if (q_data.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected strobe actual=%0h/%0d expected=none",
                 cur_tag, smp_data_o, smp_right_o);
      end else begin
        logic [31:0] ed;
        logic        er;
        string       et;
        ed = q_data.pop_front();
        er = q_right.pop_front();
        et = q_tag.pop_front();
        if (smp_data_o !== ed || smp_right_o !== er) begin
          errors++;
          $display("FAIL %s actual=%0h/%0d expected=%0h/%0d", et, smp_data_o, smp_right_o, ed, er);
        end
      end
    end
  end

  task automatic expect_word(input logic right, input logic [31:0] d, input string tag);
    q_data.push_back(d);
    q_right.push_back(right);
    q_tag.push_back(tag);
  endtask

  function automatic logic [31:0] exp_msb(input logic [63:0] w, input int wl, input int n);
    logic [63:0] r;
    if (wl >= n) r = w >> (wl - n);
    else         r = w << (n - wl);
    return r[31:0];
  endfunction

  function automatic logic [31:0] exp_tail(input logic [63:0] w, input int n);
    logic [63:0] m;
    m = (64'd1 << n) - 64'd1;
    return 32'(w & m);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk_i = 1'b0; lrck_i = 1'b0; sdata_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic apply_cfg(input logic [1:0] f, input int len);
    @(negedge clk);
    fmt_i = f;
    word_len_i = 6'(len);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_bit(input logic lr, input logic d);
    sclk_i = 1'b0; lrck_i = lr; sdata_i = d;
    repeat (4) @(negedge clk);
    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic lr, input int slot, input int lead,
                           input logic [63:0] w, input int wl);
    for (int i = 0; i < slot; i++) begin
      if (i >= lead && i < lead + wl) send_bit(lr, w[wl - 1 - (i - lead)]);
      else                           send_bit(lr, 1'b0);
    end
  endtask

  task automatic stream_pair(input logic first, input int slot, input int lead,
                             input logic [63:0] lw, input logic [63:0] rw, input int wl);
    send_half(!first, 4, 0, 64'd0, 0);
    send_half(first, slot, lead, lw, wl);
    send_half(!first, slot, lead, rw, wl);
    send_half(first, 4, 0, 64'd0, 0);
    repeat (20) @(negedge clk);
  endtask

  task automatic pair_test(input logic [1:0] f, input int n, input int slot, input int wl,
                           input logic [63:0] lw, input logic [63:0] rw, input string tag);
    logic first;
    int   lead;
    do_reset();
    apply_cfg(f, n);
    cur_tag = tag;
    if (f == 2'd0)      begin first = 1'b1; lead = 0; end
    else if (f == 2'd1) begin first = 1'b0; lead = 1; end
    else                begin first = 1'b1; lead = slot - wl; end
    if (f == 2'd2) begin
      expect_word(1'b0, exp_tail(lw, n), tag);
      expect_word(1'b1, exp_tail(rw, n), tag);
    end else begin
      expect_word(1'b0, exp_msb(lw, wl, n), tag);
      expect_word(1'b1, exp_msb(rw, wl, n), tag);
    end
    stream_pair(first, slot, lead, lw, rw, wl);
  endtask

  task automatic pulse_test(input int n, input logic [63:0] lw, input logic [63:0] rw,
                            input int kr, input string tag);
    do_reset();
    apply_cfg(2'd3, n);
    cur_tag = tag;
    expect_word(1'b0, exp_msb(lw, n, n), tag);
    expect_word(1'b1, exp_msb(rw, kr, n), tag);
    send_half(1'b0, 4, 0, 64'd0, 0);
    send_bit(1'b1, 1'b0);
    send_half(1'b0, n, 0, lw, n);
    send_half(1'b0, kr, 0, rw, kr);
    if (kr < n) send_bit(1'b1, 1'b0);
    send_half(1'b0, 4, 0, 64'd0, 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int s0;
    // R10: outputs low during and just after reset
    repeat (2) @(negedge clk);
    check_eq("R10", {smp_valid_o, smp_right_o, cfg_err_o, smp_data_o}, 64'd0);
    do_reset();
    check_eq("R10", {smp_valid_o, smp_right_o, cfg_err_o, smp_data_o}, 64'd0);

    // R10: alignment high at the first edge is not a change, so no word is produced
    apply_cfg(2'd0, 16);
    cur_tag = "R10";
    s0 = strobes;
    send_half(1'b1, 20, 0, 64'd0, 0);
    repeat (20) @(negedge clk);
    check_eq("R10", 64'(strobes - s0), 64'd0);

    // R1 R5 R9: left-justified, exact slot
    pair_test(2'd0, 16, 16, 16, 64'hA5C3, 64'h3C5A, "R1");
    pair_test(2'd0, 32, 32, 32, 64'h8000_0001, 64'hFFFF_0000, "R5");
    // R7: longer words than N are truncated at the LSB end
    pair_test(2'd0, 24, 32, 32, 64'hDEAD_BEEF, 64'h1234_5678, "R7");
    // R8: short slot, zero-filled
    pair_test(2'd0, 16, 10, 10, 64'h2B5, 64'h1C3, "R8");
    // R2: one-bit delayed format
    pair_test(2'd1, 16, 32, 16, 64'h8421, 64'h7BDE, "R2");
    pair_test(2'd1, 20, 19, 18, 64'h2AAAB, 64'h15554, "R8");
    // R3: right-justified
    pair_test(2'd2, 16, 32, 16, 64'hC0DE, 64'h0FF1, "R3");
    pair_test(2'd2, 24, 24, 24, 64'hABCDEF, 64'h123456, "R3");
    pair_test(2'd2, 31, 32, 31, 64'h2AAA_5555, 64'h7000_000F, "R3");
    // R4: pulse-framed
    pulse_test(16, 64'hBEEF, 64'hF00D, 16, "R4");
    pulse_test(16, 64'h0001, 64'h8000, 16, "R4");
    pulse_test(24, 64'hC3C3C3, 64'hA7, 8, "R8");

    // R6: illegal settings are flagged and ignored
    do_reset();
    apply_cfg(2'd0, 24);
    check_eq("R6", 64'(cfg_err_o), 64'd0);
    apply_cfg(2'd2, 32);
    check_eq("R6", 64'(cfg_err_o), 64'd1);
    cur_tag = "R6";
    expect_word(1'b0, exp_msb(64'h0F1E_2D3C, 32, 24), "R6");
    expect_word(1'b1, exp_msb(64'hC3B4_A596, 32, 24), "R6");
    stream_pair(1'b1, 32, 0, 64'h0F1E_2D3C, 64'hC3B4_A596, 32);
    apply_cfg(2'd0, 15);
    check_eq("R6", 64'(cfg_err_o), 64'd1);
    apply_cfg(2'd1, 33);
    check_eq("R6", 64'(cfg_err_o), 64'd1);
    apply_cfg(2'd1, 16);
    check_eq("R6", 64'(cfg_err_o), 64'd0);

    // R9: every expected strobe was seen
    repeat (20) @(negedge clk);
    check_eq("R9", 64'(q_data.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule